// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches a small group of external input pins and drives one interrupt line per pin. Software picks, per pin, whether the line responds to a rising edge, a falling edge, either edge, a high level or a low level. Every per-pin control and status bit lives in a single 32-bit register. The register is reached through a plain single-address port: a write strobe with write data, and read data that is always valid. The bit for pin `i` in field `f` sits at position `i + f*FIELD_W`, where the field stride `FIELD_W` is a parameter.

Each pin first passes through a two-flop synchronizer. Edge events are then latched until software acknowledges them through a clear bit. A level condition is reported live for as long as it lasts. An enable bit per pin gates the interrupt output without stopping detection, so software can poll a pin that is disabled.

A build parameter selects how the clear bit behaves. By default a 1 written to it acts for one cycle. In the held variant it stays set and blocks the pin until software writes it back to 0. There is no streaming data path, so all pins are plain control and status signals and no back-pressure applies.

Top module: `ext_irq_ctrl`

## Requirements
- R1: The block has `NUM_IN` (default 4) pin inputs and the same number of separate registered interrupt outputs; output `i` depends only on pin `i` and the bits of pin `i`.
- R2: The register holds six fields; bit `i + f*FIELD_W` (FIELD_W default 4) belongs to pin `i`, with field number f: 0 sense, 1 status, 2 clear, 3 enable, 4 any-edge, 5 level. Bits outside these fields read as 0.
- R3: With level=0, a pin latches an event in its status bit on either edge when any-edge=1, on a rising edge when any-edge=0 and sense=1, and on a falling edge when any-edge=0 and sense=0. A latched event stays set until it is cleared.
- R4: With level=1, the status bit shows the live synchronized pin: it is 1 while the pin is high if sense=1, and while the pin is low if sense=0. Clear has no lasting effect in this mode.
- R5: The interrupt output equals status AND enable, registered one cycle after the status. With enable=0 the output stays 0, but events are still latched and can be read in status.
- R6: In the default variant, writing 1 to a pin's clear bit removes its latched edge event, and the clear field always reads 0. An edge detected in the same cycle as the clear write remains latched.
- R7: In the held-clear variant (`STICKY_CLEAR=1`), the clear bit reads back as written. While it is 1, the pin's status and output stay 0 and edges are discarded. Once it is written back to 0, new edges latch again.
- R8: The status field is read-only. Writing ones to it neither sets status nor raises an output.
- R9: Reset clears the whole register to zero: falling-edge mode, all outputs disabled, no latched events, and all outputs 0.
- R10: A pin change appears in the status bit on the third rising clock edge after the change (two synchronizer stages plus one latch stage). The output follows one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_IN | Asynchronous external pins |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq_out | output | NUM_IN | Per-pin interrupt outputs |

## Verification
Assertions check on every cycle that an edge event is latched and then held until a clear, and that an acknowledge with no new edge empties the latch. They also check that a disabled pin or a held clear keeps its output low on the next cycle. The bench alone can show the end-to-end latency from a pin change, the decoding of all five trigger modes across the packed register, and the exact read-back layout. It also covers the race between an edge and an acknowledge, and the behaviour of the held-clear variant as seen from the ports.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int REG_W = 32;
  localparam int NUM_FIELDS = 6;

  // field numbers; software relies on this order
  localparam int FLD_SENSE = 0;
  localparam int FLD_STAT  = 1;
  localparam int FLD_CLR   = 2;
  localparam int FLD_EN    = 3;
  localparam int FLD_ANY   = 4;
  localparam int FLD_LVL   = 5;

  typedef struct packed {
    logic sense;
    logic any_edge;
    logic level;
    logic enable;
    logic clr_hold;
    logic clr_pulse;
  } chan_cfg_t;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
  import extirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sync_i,
  input  chan_cfg_t cfg_i,
  output logic      status_o,
  output logic      irq_o
);
  logic prev_q;
  logic lat_q;
  logic irq_q;
  logic rise, fall, hit, lvl_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_i;
  end

  assign rise = sync_i & ~prev_q;
  assign fall = ~sync_i & prev_q;

  always_comb begin
    if (cfg_i.any_edge) hit = rise | fall;
    else if (cfg_i.sense) hit = rise;
    else hit = fall;
  end

  assign lvl_active = cfg_i.sense ? sync_i : ~sync_i;

  // event latch: a fresh edge beats a simultaneous acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= 1'b0;
    else if (cfg_i.level || cfg_i.clr_hold) lat_q <= 1'b0;
    else if (cfg_i.clr_pulse) lat_q <= hit;
    else lat_q <= lat_q | hit;
  end

  always_comb begin
    if (cfg_i.clr_hold) status_o = 1'b0;
    else if (cfg_i.level) status_o = lvl_active;
    else status_o = lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= status_o & cfg_i.enable;
  end

  assign irq_o = irq_q;

  a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.level && !cfg_i.clr_hold && hit) |=> lat_q);

  a_r3_event_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.level && !cfg_i.clr_hold && !cfg_i.clr_pulse && lat_q) |=> lat_q);

  a_r6_clear_removes: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.level && cfg_i.clr_pulse && !hit) |=> !lat_q);

  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.enable) |=> !irq_o);

  a_r7_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_i.clr_hold |=> !irq_o);
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
#(
  parameter int NUM_IN       = 4,
  parameter int FIELD_W      = 4,
  parameter bit STICKY_CLEAR = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_i,
  input  logic [REG_W-1:0]        wdata_i,
  input  logic [NUM_IN-1:0]       status_i,
  output logic [REG_W-1:0]        rdata_o,
  output chan_cfg_t [NUM_IN-1:0]  cfg_o
);
  localparam int SENSE_B = FLD_SENSE * FIELD_W;
  localparam int STAT_B  = FLD_STAT  * FIELD_W;
  localparam int CLR_B   = FLD_CLR   * FIELD_W;
  localparam int EN_B    = FLD_EN    * FIELD_W;
  localparam int ANY_B   = FLD_ANY   * FIELD_W;
  localparam int LVL_B   = FLD_LVL   * FIELD_W;

  logic [NUM_IN-1:0] sense_q, en_q, any_q, lvl_q, clr_q;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IN; gi++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sense_q[gi] <= 1'b0;
          en_q[gi]    <= 1'b0;
          any_q[gi]   <= 1'b0;
          lvl_q[gi]   <= 1'b0;
        end else if (we_i) begin
          sense_q[gi] <= wdata_i[gi + SENSE_B];
          en_q[gi]    <= wdata_i[gi + EN_B];
          any_q[gi]   <= wdata_i[gi + ANY_B];
          lvl_q[gi]   <= wdata_i[gi + LVL_B];
        end
      end

      if (STICKY_CLEAR) begin : g_held
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)    clr_q[gi] <= 1'b0;
          else if (we_i) clr_q[gi] <= wdata_i[gi + CLR_B];
        end
        assign cfg_o[gi].clr_hold  = clr_q[gi];
        assign cfg_o[gi].clr_pulse = 1'b0;
      end else begin : g_pulse
        assign clr_q[gi]           = 1'b0;
        assign cfg_o[gi].clr_hold  = 1'b0;
        assign cfg_o[gi].clr_pulse = we_i & wdata_i[gi + CLR_B];
      end

      assign cfg_o[gi].sense    = sense_q[gi];
      assign cfg_o[gi].enable   = en_q[gi];
      assign cfg_o[gi].any_edge = any_q[gi];
      assign cfg_o[gi].level    = lvl_q[gi];
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      rdata_o[i + SENSE_B] = sense_q[i];
      rdata_o[i + STAT_B]  = status_i[i];
      rdata_o[i + CLR_B]   = clr_q[i];
      rdata_o[i + EN_B]    = en_q[i];
      rdata_o[i + ANY_B]   = any_q[i];
      rdata_o[i + LVL_B]   = lvl_q[i];
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import extirq_pkg::*;
#(
  parameter int NUM_IN       = 4,
  parameter int FIELD_W      = 4,
  parameter int SYNC_STAGES  = 2,
  parameter bit STICKY_CLEAR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] pin_in,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NUM_IN-1:0] irq_out
);
  chan_cfg_t [NUM_IN-1:0] cfg;
  logic [NUM_IN-1:0] pin_sync;
  logic [NUM_IN-1:0] status;

  extirq_regs #(
    .NUM_IN(NUM_IN), .FIELD_W(FIELD_W), .STICKY_CLEAR(STICKY_CLEAR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .wdata_i(reg_wdata),
    .status_i(status), .rdata_o(reg_rdata), .cfg_o(cfg)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IN; gi++) begin : g_pin
      extirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_in[gi]), .q_o(pin_sync[gi])
      );
      extirq_detect u_det (
        .clk(clk), .rst_n(rst_n), .sync_i(pin_sync[gi]), .cfg_i(cfg[gi]),
        .status_o(status[gi]), .irq_o(irq_out[gi])
      );
    end
  endgenerate
endmodule

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] pins = '0, pins_s = '0;
  logic we = 1'b0, we_s = 1'b0;
  logic [31:0] wd = '0, wd_s = '0;
  logic [31:0] rd, rd_s;
  logic [3:0] irq, irq_s;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  ext_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .pin_in(pins), .reg_we(we),
    .reg_wdata(wd), .reg_rdata(rd), .irq_out(irq));

  ext_irq_ctrl #(.STICKY_CLEAR(1'b1)) dut_s (.clk(clk), .rst_n(rst_n),
    .pin_in(pins_s), .reg_we(we_s), .reg_wdata(wd_s), .reg_rdata(rd_s),
    .irq_out(irq_s));

  // {config word, starting pins, final pins, expected status}
  localparam logic [43:0] VEC [10] = '{
    {32'h0000F000, 4'hF, 4'h0, 4'hF},  // R3 falling
    {32'h0000F000, 4'h0, 4'hF, 4'h0},  // R3 falling ignores rise
    {32'h0000F00F, 4'h0, 4'hF, 4'hF},  // R3 rising
    {32'h0000F00F, 4'hF, 4'h0, 4'h0},  // R3 rising ignores fall
    {32'h000FF000, 4'h0, 4'h5, 4'h5},  // R3 any edge up
    {32'h000FF000, 4'h5, 4'h0, 4'h5},  // R3 any edge down
    {32'h00F0F00F, 4'h0, 4'hA, 4'hA},  // R4 level high
    {32'h00F0F000, 4'h0, 4'hA, 4'h5},  // R4 level low
    {32'h00847009, 4'h0, 4'hF, 4'hD},  // R1 mixed modes, pin3 disabled
    {32'h00847009, 4'hF, 4'h0, 4'h6}   // R1 mixed modes reversed
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); we = 1'b1; wd = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wr_s(input logic [31:0] v);
    @(negedge clk); we_s = 1'b1; wd_s = v;
    @(negedge clk); we_s = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset rdata", rd, 32'h0);
    chk("R9 reset irq", {28'h0, irq}, 32'h0);

    // table walk
    for (int v = 0; v < 10; v++) begin
      logic [31:0] cfg;
      logic [3:0] expst;
      cfg = VEC[v][43:12];
      expst = VEC[v][3:0];
      pins = VEC[v][11:8];
      idle(6);
      wr(cfg | 32'h00000F00);
      pins = VEC[v][7:4];
      idle(6);
      chk($sformatf("R3/R4 vec%0d status", v), {28'h0, rd[7:4]}, {28'h0, expst});
      chk($sformatf("R1/R5 vec%0d irq", v), {28'h0, irq}, {28'h0, expst & cfg[15:12]});
    end

    // R10 latency, pin0 rising and enabled
    pins = 4'h0; idle(6);
    wr(32'h00001F01);
    idle(2);
    pins[0] = 1'b1;
    @(negedge clk); chk("R10 status after edge 1", {31'h0, rd[4]}, 32'h0);
    @(negedge clk); chk("R10 status after edge 2", {31'h0, rd[4]}, 32'h0);
    @(negedge clk); chk("R10 status after edge 3", {31'h0, rd[4]}, 32'h1);
    chk("R10 irq after edge 3", {31'h0, irq[0]}, 32'h0);
    @(negedge clk); chk("R10 irq after edge 4", {31'h0, irq[0]}, 32'h1);

    // R5 disabled pin still latches
    pins = 4'h0; idle(6);
    wr(32'h00000F04);
    pins[2] = 1'b1; idle(6);
    chk("R5 latched while disabled", {31'h0, rd[6]}, 32'h1);
    chk("R5 output quiet while disabled", {31'h0, irq[2]}, 32'h0);
    wr(32'h00004004);
    idle(1);
    chk("R5 output after enable", {31'h0, irq[2]}, 32'h1);

    // R6 acknowledge
    wr(32'h00004404);
    chk("R6 status cleared", {31'h0, rd[6]}, 32'h0);
    chk("R6 clear reads zero", {28'h0, rd[11:8]}, 32'h0);
    idle(1);
    chk("R6 irq dropped", {31'h0, irq[2]}, 32'h0);

    // R6 edge in the same cycle as the acknowledge
    pins = 4'h0; idle(6);
    wr(32'h00002F02);
    pins[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    we = 1'b1; wd = 32'h00002202;
    @(negedge clk);
    we = 1'b0;
    chk("R6 edge beats clear", {31'h0, rd[5]}, 32'h1);

    // R8 status read-only
    pins = 4'h0; idle(6);
    wr(32'h00000F00);
    wr(32'h0000F0F0);
    idle(2);
    chk("R8 status not writable", {28'h0, rd[7:4]}, 32'h0);
    chk("R8 no irq from status write", {28'h0, irq}, 32'h0);

    // R2 layout and unused bits, level high on all pins
    pins = 4'h6; idle(6);
    wr(32'hFFFFFFFF);
    chk("R2 full readback", rd, 32'h00FFF06F);

    // R7 held clear variant
    wr_s(32'h00001101);
    chk("R7 clear reads back", {31'h0, rd_s[8]}, 32'h1);
    pins_s[0] = 1'b1; idle(6);
    chk("R7 status blocked", {31'h0, rd_s[4]}, 32'h0);
    chk("R7 irq blocked", {31'h0, irq_s[0]}, 32'h0);
    wr_s(32'h00001001);
    idle(2);
    chk("R7 no stale event after release", {31'h0, rd_s[4]}, 32'h0);
    pins_s[0] = 1'b0; idle(6);
    pins_s[0] = 1'b1; idle(6);
    chk("R7 latches after release", {31'h0, rd_s[4]}, 32'h1);
    chk("R7 irq after release", {31'h0, irq_s[0]}, 32'h1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule